// File: doc/BRIEF.md
# Dual-Channel Converter Code Holding Stage

This block sits between a register write port and two digital-to-analog converters. A write carries a data word, a channel selector and a format selector. The block turns the data into a 12-bit converter code and stores it in that channel's holding register. It then moves the held code into the channel's output register. That transfer happens either one clock after the write, or, when the channel is in triggered mode, on a trigger pulse.

Three input formats are accepted:

- a narrow 8-bit sample, which is scaled up to the top of the code;
- a 12-bit sample taken from the low end of a 16-bit lane;
- a 12-bit sample taken from the high end of that lane.

A single combined write fills both channels from one 32-bit word. In automatic mode, both outputs then change on the same clock edge. The converter code is intended to set the output to the reference voltage times code/4095. Code 4095 is therefore full scale.

Top module: `dac_hold_top`

## Requirements
- R1: While rst_ni is low, and after it is released with no write, both output codes are 0.
- R2: Format 0 (8-bit) takes lane bits [7:0] and places them in code bits [11:4], with code bits [3:0] set to 0.
- R3: Format 1 (12-bit low-aligned) takes lane bits [11:0] as the code; lane bits [15:12] have no effect.
- R4: Format 2 (12-bit high-aligned) takes lane bits [15:4] as the code; lane bits [3:0] have no effect.
- R5: Selector 0 writes channel 0 and selector 1 writes channel 1. Both use lane bits [15:0] of the data word. The other channel's output is unchanged.
- R6: Selector 2 is a combined write. Channel 0 takes lane bits [15:0] and channel 1 takes lane bits [31:16], both in the same format. In automatic mode both outputs change on the same edge.
- R7: With a channel's trigger mode off, its output takes the written code at the second rising edge after the write is sampled. Later writes are applied in order, one per cycle. Trigger pulses have no effect.
- R8: With trigger mode on, the output keeps its value until trig_i for that channel is sampled high, and then loads the held code on that edge. A write sampled on the same edge as the trigger is not the value transferred; the previous held code is.
- R9: A disabled channel's output is 0 from the edge after its enable is sampled low. Writes made while a channel is disabled do not reach its output. After re-enabling, the output stays 0 until a new transfer.
- R10: A write with format 3 or selector 3 changes neither the held codes nor the outputs.
- R11: Code 4095 (0xFFF) is full scale, giving an output ratio of code/4095 = 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_sel_i | input | 2 | 0 channel 0, 1 channel 1, 2 both, 3 ignored |
| wr_fmt_i | input | 2 | 0 8-bit, 1 12-bit low-aligned, 2 12-bit high-aligned, 3 ignored |
| wr_data_i | input | 32 | Write data, lane 0 in [15:0] and lane 1 in [31:16] |
| ch_en_i | input | 2 | Per-channel enable |
| trig_en_i | input | 2 | Per-channel triggered-mode select |
| trig_i | input | 2 | Per-channel transfer trigger pulse |
| dac0_code_o | output | 12 | Channel 0 converter code |
| dac1_code_o | output | 12 | Channel 1 converter code |

## Verification
In triggered mode, a write into the holding register and a trigger-driven transfer can occur on the same edge. The bench provokes this by asserting the write strobe and the trigger in the same cycle, with the held value differing from the newly written one. It requires that the output take the older held code on that edge, and that the new code appear only after a second trigger. Back-to-back automatic writes exercise the analogous overlap, where one write's pending transfer coincides with the next write's load.

// File: rtl/dac_hold_pkg.sv
package dac_hold_pkg;
  typedef enum logic [1:0] {
    FMT_R8  = 2'd0,
    FMT_R12 = 2'd1,
    FMT_L12 = 2'd2,
    FMT_RSV = 2'd3
  } dac_fmt_e;

  typedef enum logic [1:0] {
    SEL_CH0  = 2'd0,
    SEL_CH1  = 2'd1,
    SEL_DUAL = 2'd2,
    SEL_RSV  = 2'd3
  } dac_sel_e;
endpackage

// File: rtl/dac_fmt.sv
module dac_fmt
  import dac_hold_pkg::*;
#(
  parameter int unsigned LANE_W   = 16,
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned NARROW_W = 8
) (
  input  dac_fmt_e            fmt_i,
  input  logic [LANE_W-1:0]   lane_i,
  output logic [CODE_W-1:0]   code_o
);
  localparam int unsigned PAD_W = CODE_W - NARROW_W;

  always_comb begin
    unique case (fmt_i)
      FMT_R8:  code_o = {lane_i[NARROW_W-1:0], {PAD_W{1'b0}}};
      FMT_R12: code_o = lane_i[CODE_W-1:0];
      FMT_L12: code_o = lane_i[LANE_W-1 -: CODE_W];
      default: code_o = '0;
    endcase
  end
endmodule

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
  import dac_hold_pkg::*;
#(
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned N_CH     = 2
) (
  input  logic                         wr_en_i,
  input  dac_sel_e                     sel_i,
  input  dac_fmt_e                     fmt_i,
  input  logic [BUS_W-1:0]             data_i,
  output logic [N_CH-1:0]              ld_o,
  output logic [N_CH-1:0][CODE_W-1:0]  code_o
);
  localparam int unsigned LANE_W = BUS_W / N_CH;

  logic fmt_ok;
  assign fmt_ok = (fmt_i != FMT_RSV);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [LANE_W-1:0] lane;
    logic              hit;

    // combined writes spread lanes across channels; single writes use lane 0
    assign lane = (sel_i == SEL_DUAL) ? data_i[c*LANE_W +: LANE_W] : data_i[LANE_W-1:0];
    assign hit  = (sel_i == SEL_DUAL) ||
                  ((c == 0) ? (sel_i == SEL_CH0) : (sel_i == SEL_CH1));
    assign ld_o[c] = wr_en_i && fmt_ok && hit;

    dac_fmt #(
      .LANE_W  (LANE_W),
      .CODE_W  (CODE_W),
      .NARROW_W(NARROW_W)
    ) u_fmt (
      .fmt_i (fmt_i),
      .lane_i(lane),
      .code_o(code_o[c])
    );
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [CODE_W-1:0] ld_code_i,
  input  logic              en_i,
  input  logic              trig_en_i,
  input  logic              trig_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] hold_q;
  logic              pend_q;
  logic              xfer;

  assign xfer = en_i && (trig_en_i ? trig_i : pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      code_o <= '0;
    end else begin
      if (ld_i) hold_q <= ld_code_i;
      pend_q <= ld_i && en_i && !trig_en_i;
      if (!en_i)     code_o <= '0;
      else if (xfer) code_o <= hold_q;  // old hold wins on a same-edge write
    end
  end

  a_r9_disabled_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> code_o == '0);

  a_r8_trig_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && trig_en_i && !trig_i |=> $stable(code_o));

  a_r8_trig_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && trig_en_i && trig_i |=> code_o == $past(hold_q));

  a_r7_auto_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && en_i && !trig_en_i ##1 en_i && !trig_en_i |=> code_o == $past(ld_code_i, 2));
endmodule

// File: rtl/dac_hold_top.sv
module dac_hold_top
  import dac_hold_pkg::*;
#(
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [1:0]        wr_fmt_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic [1:0]        ch_en_i,
  input  logic [1:0]        trig_en_i,
  input  logic [1:0]        trig_i,
  output logic [CODE_W-1:0] dac0_code_o,
  output logic [CODE_W-1:0] dac1_code_o
);
  localparam int unsigned N_CH = 2;

  logic [N_CH-1:0]             wd_ld;
  logic [N_CH-1:0][CODE_W-1:0] wd_code;
  logic [N_CH-1:0][CODE_W-1:0] ch_code;

  dac_wr_decode #(
    .BUS_W   (BUS_W),
    .CODE_W  (CODE_W),
    .NARROW_W(NARROW_W),
    .N_CH    (N_CH)
  ) u_dec (
    .wr_en_i(wr_en_i),
    .sel_i  (dac_sel_e'(wr_sel_i)),
    .fmt_i  (dac_fmt_e'(wr_fmt_i)),
    .data_i (wr_data_i),
    .ld_o   (wd_ld),
    .code_o (wd_code)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    dac_chan #(.CODE_W(CODE_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (wd_ld[c]),
      .ld_code_i(wd_code[c]),
      .en_i     (ch_en_i[c]),
      .trig_en_i(trig_en_i[c]),
      .trig_i   (trig_i[c]),
      .code_o   (ch_code[c])
    );
  end

  assign dac0_code_o = ch_code[0];
  assign dac1_code_o = ch_code[1];

  a_r10_rsv_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fmt_i == 2'd3 || wr_sel_i == 2'd3) |-> wd_ld == '0);

  a_r5_single_one_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i != 2'd2 |-> $countones(wd_ld) <= 1);

  a_r6_dual_same_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_ld == 2'b11 && ch_en_i == 2'b11 && trig_en_i == 2'b00 ##1
    ch_en_i == 2'b11 && trig_en_i == 2'b00
    |=> dac0_code_o == $past(wd_code[0], 2) && dac1_code_o == $past(wd_code[1], 2));
endmodule

// File: tb/tb_dac_hold_top.sv
module tb_dac_hold_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [1:0]  wr_fmt = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  ch_en = '0;
  logic [1:0]  trig_en = '0;
  logic [1:0]  trig = '0;
  logic [11:0] code0, code1;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    int          at;
    logic [11:0] e0;
    logic [11:0] e1;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;  // 250 MHz

  dac_hold_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_fmt_i(wr_fmt), .wr_data_i(wr_data), .ch_en_i(ch_en),
    .trig_en_i(trig_en), .trig_i(trig), .dac0_code_o(code0), .dac1_code_o(code1)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations at their due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      n_chk++;
      if (q[0].at < cyc || code0 !== q[0].e0 || code1 !== q[0].e1) begin
        n_bad++;
        $display("FAIL %s: got %h/%h expected %h/%h (due %0d now %0d)",
                 q[0].tag, code0, code1, q[0].e0, q[0].e1, q[0].at, cyc);
      end
      void'(q.pop_front());
    end
  end

  task automatic check(input logic ok, input string tag, input string got, input string exp_s);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %s expected %s", tag, got, exp_s);
    end
  endtask

  task automatic push(input int dly, input logic [11:0] e0, input logic [11:0] e1, input string tag);
    item_t it;
    it.at = cyc + dly; it.e0 = e0; it.e1 = e1; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      trig  = '0;
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] fmt, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_fmt = fmt; wr_data = d;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    tick(3);
    check(code0 == 0 && code1 == 0, "R1 in reset", $sformatf("%h/%h", code0, code1), "000/000");
    rst_ni = 1'b1;
    tick(2);
    check(code0 == 0 && code1 == 0, "R1 after reset", $sformatf("%h/%h", code0, code1), "000/000");
    ch_en = 2'b11; trig_en = 2'b00;
    tick(2);

    wr(2'd0, 2'd0, 32'h0000_12A5);          // R2 R5
    push(1, 12'h000, 12'h000, "R7 no early update");
    push(2, 12'hA50, 12'h000, "R2 8-bit ch0");
    tick(3);
    wr(2'd1, 2'd1, 32'hFFFF_F7FF);          // R3 R5
    push(2, 12'hA50, 12'h7FF, "R3 low-aligned ch1");
    tick(3);
    wr(2'd0, 2'd2, 32'h1234_ABCF);          // R4
    push(2, 12'hABC, 12'h7FF, "R4 high-aligned ch0");
    tick(3);
    wr(2'd2, 2'd1, 32'h0123_0456);          // R6
    push(1, 12'hABC, 12'h7FF, "R6 dual not early");
    push(2, 12'h456, 12'h123, "R6 dual low-aligned");
    tick(3);
    wr(2'd2, 2'd0, 32'h77CC_9933);
    push(2, 12'h330, 12'hCC0, "R6 dual 8-bit");
    tick(3);
    wr(2'd2, 2'd2, 32'hDEF0_9871);
    push(2, 12'h987, 12'hDEF, "R6 dual high-aligned");
    tick(3);

    wr(2'd0, 2'd1, 32'h0000_0111);          // R7 back-to-back
    push(2, 12'h111, 12'hDEF, "R7 first of pair");
    tick(1);
    wr(2'd0, 2'd1, 32'h0000_0222);
    push(2, 12'h222, 12'hDEF, "R7 second of pair");
    tick(3);
    trig = 2'b11;                           // R7 trigger ignored
    push(1, 12'h222, 12'hDEF, "R7 trigger ignored");
    tick(3);

    wr(2'd1, 2'd1, 32'h0000_0FFF);          // R11
    push(2, 12'h222, 12'hFFF, "R11 full-scale code");
    tick(3);
    check(real'(code1) / 4095.0 == 1.0, "R11 full-scale ratio",
          $sformatf("%f", real'(code1) / 4095.0), "1.000000");

    trig_en = 2'b01;                        // R8
    tick(1);
    wr(2'd0, 2'd1, 32'h0000_0333);
    push(3, 12'h222, 12'hFFF, "R8 holds without trigger");
    tick(4);
    trig = 2'b01;
    push(1, 12'h333, 12'hFFF, "R8 trigger transfer");
    tick(3);
    wr(2'd0, 2'd1, 32'h0000_0444);          // R8 same-edge write and trigger
    trig = 2'b01;
    push(1, 12'h333, 12'hFFF, "R8 collision takes old hold");
    tick(1);
    trig = 2'b01;
    push(1, 12'h444, 12'hFFF, "R8 next trigger takes new hold");
    tick(3);

    trig_en = 2'b00;                        // R10
    tick(1);
    wr(2'd0, 2'd3, 32'h0000_0555);
    push(2, 12'h444, 12'hFFF, "R10 format 3 ignored");
    tick(3);
    wr(2'd3, 2'd1, 32'h0666_0666);
    push(2, 12'h444, 12'hFFF, "R10 selector 3 ignored");
    tick(3);

    ch_en = 2'b01;                          // R9
    push(1, 12'h444, 12'h000, "R9 disable clears");
    tick(2);
    wr(2'd1, 2'd1, 32'h0000_0777);
    push(2, 12'h444, 12'h000, "R9 write while disabled");
    tick(3);
    ch_en = 2'b11;
    push(1, 12'h444, 12'h000, "R9 re-enable stays zero");
    push(3, 12'h444, 12'h000, "R9 re-enable still zero");
    tick(4);
    wr(2'd1, 2'd1, 32'h0000_0888);
    push(2, 12'h444, 12'h888, "R9 new transfer after enable");
    tick(4);

    wait (q.size() == 0);
    tick(1);
    summary();
  end
endmodule